// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a small synchronous static memory with a two-bit burst address sequencer. Address, write data, chip enables, both address strobes, the advance input and all write controls are sampled on the rising clock edge. A cycle opened by either strobe loads a fresh address. While a burst is open, later cycles take their address from an internal two-bit counter that steps the two low address bits. The counter runs in linear or interleaved order, as selected by a mode input. When the advance input is high the counter holds, so the cycle repeats the current address. Each cycle of an open burst is a read or a write, as set by that cycle's write controls.

Reads come out in one of two ways. In flow-through mode the array output goes straight to the data pins in the cycle after the read is captured. In pipelined mode a data register adds one more cycle. The data bus is split into a value and a drive enable, which together model a tri-state pad. The drive follows a single-cycle-deselect rule: the enable comes from a one-stage history of read cycles. Output enable gates the drive combinationally, without waiting for a clock. The bus has fixed latency and no valid/ready handshake, so it applies no back-pressure. A new address may be loaded on every clock.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset the data drive is off and no burst is open. A cycle with advance low and no strobe neither reads nor writes.
- R2: The processor strobe (adsp_n low) with the chip selected loads addr and starts a read. It takes priority over the controller strobe and ignores all write controls.
- R3: The controller strobe (adsc_n low, adsp_n high) with the chip selected loads addr. The cycle is a write when gw_n is low, or when bwe_n is low with at least one bsel_n bit low. Otherwise it is a read.
- R4: With ilv_mode low, the two low address bits of a burst started at S are S, S+1, S+2, S+3 (modulo 4). Each cycle with adv_n low and no strobe takes the next value. The upper address bits stay fixed.
- R5: With ilv_mode high, the low bits are S, S xor 1, S xor 2, S xor 3.
- R6: On the fifth address of a burst, the counter returns to the start address.
- R7: In an open burst, a cycle with adv_n high and no strobe repeats the current address.
- R8: gw_n low writes every byte lane whatever bsel_n holds. Byte lane i (bits 8i+7..8i) is written only when gw_n is high, bwe_n is low and bsel_n[i] is low. Other lanes keep their contents.
- R9: With pipe_mode low, data read in the cycle captured at edge e is on dq_out, and dq_drv is high, after edge e.
- R10: With pipe_mode high, the same data appears after edge e+1.
- R11: The chip is selected only when ce_lo_n is low and ce_hi is high. A strobe while it is not selected closes the burst and is a deselect. The drive turns off after the next edge in flow-through mode, and one edge later in pipelined mode.
- R12: oe_n high forces dq_drv low. A read with oe_n high (a dummy read) still steps the burst counter.
- R13: Strobes on consecutive cycles each load a new address, and every one of those reads returns its own data with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| addr | input | ADDR_W | Word address, loaded on a strobe |
| adsp_n | input | 1 | Processor address strobe, active low, always a read |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_lo_n | input | 1 | Active-low chip enable |
| ce_hi | input | 1 | Active-high chip enable |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | NBYTES | Per-lane byte strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| pipe_mode | input | 1 | 1 pipelined reads, 0 flow-through |
| ilv_mode | input | 1 | 1 interleaved burst order, 0 linear |
| dq_in | input | NBYTES*BYTE_W | Write data, sampled with the write cycle |
| dq_out | output | NBYTES*BYTE_W | Read data |
| dq_drv | output | 1 | Drive enable of the data pads |

## Verification
The bench first fills the array with a global write, giving each word its own value. Every later read therefore shows which address the sequencer produced. It then sweeps all four start offsets under both burst orders and both output modes. Each burst runs to the fifth advance, so a wrong order, a missed wrap or a stuck suspend shows up as wrong data. Byte-masked write bursts use every strobe pattern, including all strobes high, which must fall back to a read. These separate global writes from byte writes and from reads. Sequences of dummy reads, deselects with each enable false, strobes issued together and back-to-back strobes separate the priority rule, the counter stepping with the output gated, and the single-cycle turn-off timing of each mode.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  // low address bits for burst step k from start s
  function automatic logic [1:0] burst_low(input logic [1:0] s,
                                           input logic [1:0] k,
                                           input logic ilv);
    logic [1:0] r;
    if (ilv) r = s ^ k;
    else     r = s + k;
    return r;
  endfunction
endpackage

// File: rtl/sbs_burst_ctl.sv
module sbs_burst_ctl
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce_lo_n,
  input  logic              ce_hi,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [NBYTES-1:0] bsel_n,
  input  logic              ilv_mode,
  output cyc_e              cyc_op,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [NBYTES-1:0] wmask
);
  logic [ADDR_W-1:0] base_q, base_nx;
  logic [1:0]        cnt_q, cnt_nx;
  logic              act_q, act_nx;
  logic              sel, wr_req, load, adv_tk;
  logic [NBYTES-1:0] req_mask;

  always_comb begin
    sel      = !ce_lo_n && ce_hi;
    wr_req   = !gw_n || (!bwe_n && !(&bsel_n));
    req_mask = !gw_n ? {NBYTES{1'b1}} : (!bwe_n ? ~bsel_n : {NBYTES{1'b0}});
    load     = 1'b0;
    adv_tk   = 1'b0;
    cyc_op   = CYC_IDLE;
    cnt_nx   = cnt_q;
    act_nx   = act_q;
    base_nx  = base_q;
    if (!adsp_n) begin
      if (sel) begin
        load   = 1'b1;
        cyc_op = CYC_READ;
      end else begin
        act_nx = 1'b0;
      end
    end else if (!adsc_n) begin
      if (sel) begin
        load   = 1'b1;
        cyc_op = wr_req ? CYC_WRITE : CYC_READ;
      end else begin
        act_nx = 1'b0;
      end
    end else if (act_q) begin
      cyc_op = wr_req ? CYC_WRITE : CYC_READ;
      if (!adv_n) begin
        adv_tk = 1'b1;
        cnt_nx = cnt_q + 2'd1;
      end
    end
    if (load) begin
      base_nx = addr;
      cnt_nx  = 2'd0;
      act_nx  = 1'b1;
    end
    cyc_addr = load ? addr
                    : {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nx, ilv_mode)};
    wmask    = (cyc_op == CYC_WRITE) ? req_mask : {NBYTES{1'b0}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      act_q  <= 1'b0;
    end else begin
      base_q <= base_nx;
      cnt_q  <= cnt_nx;
      act_q  <= act_nx;
    end
  end

  // R2: a load restarts the counter and opens the burst
  a_r2_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (act_q && cnt_q == 2'd0));

  // R4: an advance steps the counter by one
  a_r4_adv_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv_tk |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R7: suspend cycles hold the counter
  a_r7_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && adsp_n && adsc_n && adv_n) |=> $stable(cnt_q));

  // R11: a strobe while unselected closes the burst
  a_r11_desel_close: assert property (@(posedge clk) disable iff (!rst_n)
    ((!adsp_n || !adsc_n) && !(!ce_lo_n && ce_hi)) |=> !act_q);
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic [NBYTES-1:0]        wmask,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [NBYTES*BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wmask[b]) lane_mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
    end
    assign rdata[b*BYTE_W +: BYTE_W] = lane_mem[raddr];
  end
endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              cyc_op,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              pipe_mode,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drv
);
  logic              vld1_q, vld2_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DATA_W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld1_q    <= 1'b0;
      vld2_q    <= 1'b0;
      rd_addr_q <= '0;
      pipe_q    <= '0;
    end else begin
      vld1_q    <= (cyc_op == CYC_READ);
      vld2_q    <= vld1_q;
      rd_addr_q <= cyc_addr;
      pipe_q    <= arr_rdata;
    end
  end

  assign rd_addr = rd_addr_q;
  assign dq_out  = pipe_mode ? pipe_q : arr_rdata;
  assign dq_drv  = (pipe_mode ? vld2_q : vld1_q) && !oe_n;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     adsp_n,
  input  logic                     adsc_n,
  input  logic                     adv_n,
  input  logic                     ce_lo_n,
  input  logic                     ce_hi,
  input  logic                     gw_n,
  input  logic                     bwe_n,
  input  logic [NBYTES-1:0]        bsel_n,
  input  logic                     oe_n,
  input  logic                     pipe_mode,
  input  logic                     ilv_mode,
  input  logic [NBYTES*BYTE_W-1:0] dq_in,
  output logic [NBYTES*BYTE_W-1:0] dq_out,
  output logic                     dq_drv
);
  localparam int DATA_W = NBYTES * BYTE_W;

  cyc_e              cyc_op;
  logic [ADDR_W-1:0] cyc_addr, rd_addr;
  logic [NBYTES-1:0] wmask;
  logic [DATA_W-1:0] arr_rdata;

  sbs_burst_ctl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce_lo_n(ce_lo_n), .ce_hi(ce_hi), .gw_n(gw_n), .bwe_n(bwe_n),
    .bsel_n(bsel_n), .ilv_mode(ilv_mode), .cyc_op(cyc_op), .cyc_addr(cyc_addr),
    .wmask(wmask)
  );

  sbs_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_arr (
    .clk(clk), .wmask(wmask), .waddr(cyc_addr), .wdata(dq_in),
    .raddr(rd_addr), .rdata(arr_rdata)
  );

  sbs_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .cyc_op(cyc_op), .cyc_addr(cyc_addr),
    .pipe_mode(pipe_mode), .oe_n(oe_n), .arr_rdata(arr_rdata),
    .rd_addr(rd_addr), .dq_out(dq_out), .dq_drv(dq_drv)
  );

  // R8: no lane is written outside a write cycle
  a_r8_mask_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_op != CYC_WRITE) |-> (wmask == '0));

  // R9: flow-through read drives in the next cycle unless gated
  a_r9_flow_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && cyc_op == CYC_READ) |=> (dq_drv || oe_n));

  // R10: pipelined read drives two edges on unless gated
  a_r10_pipe_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && cyc_op == CYC_READ) |=> ##1 (dq_drv || oe_n));

  // R11: flow-through turn-off after a non-read cycle
  a_r11_flow_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && cyc_op != CYC_READ) |=> !dq_drv);

  // R11: pipelined turn-off one edge later
  a_r11_pipe_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && cyc_op != CYC_READ) |=> ##1 !dq_drv);
endmodule

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int BW = 8;
  localparam int DW = NB * BW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic          adsp_n, adsc_n, adv_n, ce_lo_n, ce_hi, gw_n, bwe_n, oe_n;
  logic [NB-1:0] bsel_n;
  logic          pipe_mode, ilv_mode;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_drv;

  sync_burst_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce_lo_n(ce_lo_n), .ce_hi(ce_hi), .gw_n(gw_n), .bwe_n(bwe_n),
    .bsel_n(bsel_n), .oe_n(oe_n), .pipe_mode(pipe_mode), .ilv_mode(ilv_mode),
    .dq_in(dq_in), .dq_out(dq_out), .dq_drv(dq_drv)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [DW-1:0] mem_m [1 << AW];
  logic [AW-1:0] m_base;
  logic [1:0]    m_k;
  logic          m_act;
  logic          prev_rd;
  logic [DW-1:0] prev_d;

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return {8'(a * 3 + 1 + salt), 8'(a ^ 8'hC3 ^ salt)};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [DW:0] act, input logic [DW:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual drv/data=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic pm, input logic im);
    rst_n = 1'b0;
    adsp_n = 1; adsc_n = 1; adv_n = 1; ce_lo_n = 1; ce_hi = 0;
    gw_n = 1; bwe_n = 1; bsel_n = '1; oe_n = 0; addr = '0; dq_in = '0;
    pipe_mode = pm; ilv_mode = im;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_act = 0; m_k = 0; m_base = '0; prev_rd = 0; prev_d = '0;
    @(negedge clk);
    check(dq_drv === 1'b0, "R1 reset drive", {dq_drv, dq_out}, '0);
  endtask

  // one clock; expected values from the requirements
  task automatic step(input logic p_n, input logic c_n, input logic v_n,
                      input logic e1n, input logic e2, input logic g_n,
                      input logic b_n, input logic [NB-1:0] bs, input logic o_n,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input string tag);
    logic sel, wr, rd, edrv;
    logic [NB-1:0] mk;
    logic [AW-1:0] ea;
    logic [1:0] lo;
    logic [DW-1:0] cd, edat;
    adsp_n = p_n; adsc_n = c_n; adv_n = v_n; ce_lo_n = e1n; ce_hi = e2;
    gw_n = g_n; bwe_n = b_n; bsel_n = bs; oe_n = o_n; addr = a; dq_in = d;
    sel = !e1n && e2;
    wr  = !g_n || (!b_n && bs != '1);
    mk  = !g_n ? '1 : (!b_n ? ~bs : '0);
    rd  = 0;
    ea  = '0;
    if (!p_n) begin
      mk = '0;
      if (sel) begin m_base = a; m_k = 0; m_act = 1; ea = a; rd = 1; end
      else m_act = 0;
    end else if (!c_n) begin
      if (sel) begin m_base = a; m_k = 0; m_act = 1; ea = a; rd = !wr; end
      else begin m_act = 0; mk = '0; end
    end else if (m_act) begin
      if (!v_n) m_k = m_k + 2'd1;
      lo = ilv_mode ? (m_base[1:0] ^ m_k) : (m_base[1:0] + m_k);
      ea = {m_base[AW-1:2], lo};
      rd = !wr;
    end else begin
      mk = '0;
    end
    cd = mem_m[ea];
    for (int b = 0; b < NB; b++)
      if (mk[b]) mem_m[ea][b*BW +: BW] = d[b*BW +: BW];
    @(posedge clk);
    @(negedge clk);
    if (pipe_mode) begin edrv = prev_rd && !o_n; edat = prev_d; end
    else           begin edrv = rd && !o_n;      edat = cd;     end
    prev_rd = rd;
    prev_d  = cd;
    check((dq_drv === edrv) && (!edrv || dq_out === edat), tag,
          {dq_drv, dq_out}, {edrv, edat});
  endtask

  // shorthands
  task automatic idle(input string tag);
    step(1, 1, 1, 1, 0, 1, 1, '1, 0, '0, '0, tag);
  endtask

  task automatic rd_adsp(input logic [AW-1:0] a, input logic o_n, input string tag);
    // controller strobe and global write also asserted: processor strobe wins
    step(0, 0, 1, 0, 1, 0, 1, '1, o_n, a, 16'hDEAD, tag);
  endtask

  task automatic rd_adsc(input logic [AW-1:0] a, input string tag);
    step(1, 0, 1, 0, 1, 1, 1, '1, 0, a, 16'hBEEF, tag);
  endtask

  task automatic adv_rd(input logic o_n, input string tag);
    step(1, 1, 0, 0, 1, 1, 1, '1, o_n, '0, 16'h1234, tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int cfg = 0; cfg < 4; cfg++) begin
      do_reset(cfg[1], cfg[0]);
      // R1: advance without an open burst does nothing
      adv_rd(0, "R1 no burst");
      if (cfg == 0) begin
        for (int a = 0; a < (1 << AW); a++)
          step(1, 0, 1, 0, 1, 0, 1, 2'b01, 1, AW'(a), pat(a, 0), "R8 global fill");
        idle("R8 fill end");
      end
      // burst reads, every start offset, run to wrap
      for (int s = 0; s < 4; s++) begin
        rd_adsp(AW'(8 + 4 * cfg + s), 0, "R2 strobe read");
        for (int k = 0; k < 3; k++)
          adv_rd(0, cfg[0] ? "R5 interleaved step" : "R4 linear step");
        adv_rd(0, "R6 wrap to start");
        step(1, 1, 1, 0, 1, 1, 1, '1, 0, '0, '0, "R7 suspend");
        adv_rd(0, "R6 after wrap");
      end
      // byte-masked write burst, then read back
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] wa;
        wa = AW'(32 + 4 * (cfg % 2) + s);
        step(1, 0, 1, 0, 1, 1, 0, 2'b10, 1, wa, pat(s, cfg + 7), "R3 byte write load");
        step(1, 1, 0, 0, 1, 1, 0, 2'b01, 1, '0, pat(s, cfg + 9), "R8 high lane");
        step(1, 1, 0, 0, 1, 1, 0, 2'b00, 1, '0, pat(s, cfg + 11), "R8 both lanes");
        step(1, 1, 0, 0, 1, 1, 0, 2'b11, 0, '0, pat(s, cfg + 13), "R3 no lanes reads");
        step(1, 1, 0, 0, 1, 0, 0, 2'b11, 1, '0, pat(s, cfg + 15), "R8 global over strobes");
        idle("R11 idle");
        rd_adsc(wa, "R3 read back");
        for (int k = 0; k < 4; k++) adv_rd(0, "R8 read back");
      end
      // dummy reads keep stepping
      rd_adsp(AW'(16 + cfg), 1, "R12 dummy read");
      adv_rd(1, "R12 dummy step");
      adv_rd(0, "R12 counter advanced");
      adv_rd(0, "R12 counter advanced");
      // turnaround to a write without a deselect
      step(1, 0, 1, 0, 1, 0, 1, '1, 1, AW'(48 + cfg), pat(cfg, 21), "R12 turnaround write");
      rd_adsc(AW'(48 + cfg), "R12 turnaround readback");
      // deselect with each enable false
      rd_adsc(AW'(20), "R11 before deselect");
      step(1, 0, 1, 1, 1, 1, 1, '1, 0, AW'(21), '0, "R11 ce_lo_n high");
      adv_rd(0, "R11 burst closed");
      idle("R11 off");
      rd_adsp(AW'(22), 0, "R11 before deselect");
      step(0, 1, 1, 0, 0, 1, 1, '1, 0, AW'(23), '0, "R11 ce_hi low");
      adv_rd(0, "R11 burst closed");
      idle("R11 off");
      // back-to-back strobes
      for (int i = 0; i < 6; i++) begin
        if (i % 2 == 0) rd_adsc(AW'(40 + 3 * i), "R13 back-to-back");
        else            rd_adsp(AW'(40 + 3 * i), 0, "R13 back-to-back");
      end
      idle("R13 drain");
      idle("R13 drain");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule